// File: doc/BRIEF.md
# Serial DAC Write Controller

This controller sits on the host side of a 14-bit serial-input voltage DAC. It accepts a code on a valid/ready handshake, frames it with an active-low chip select, clocks it out most significant bit first on a serial clock derived from the system clock, and then, if asked to, issues an active-low load strobe so the DAC register takes the new word. Every interface minimum (select setup and hold, clock phase widths, select high time between frames, strobe delay and strobe width) is converted at elaboration into whole system-clock cycles, rounded up.

Each request also carries a mode bit. In pulse mode the load line idles high and produces one timed low pulse after the frame. In tied mode the load line is held low, as if strapped to ground, so the DAC updates at the end of each frame without a pulse. A one-cycle done pulse marks the end of each transaction. At the same time a shadow copy of the last written code is updated. The shadow copy starts at zero after reset, matching the cleared DAC output.

Top module: `dacwr_ctrl`

## Requirements
- R1: After reset cs_n is 1, sclk is 0, ldac_n is 1, sdo is 0, req_ready is 1, done is 0 and shadow_code is 0.
- R2: Each frame (cs_n low) contains exactly 14 rising edges of sclk; the sdo values sampled at those edges, first edge first, equal req_code bit 13 down to bit 0.
- R3: sdo changes only while sclk is low; it is stable for the whole of every sclk high phase.
- R4: cs_n falls at least 2 system cycles (15 ns at 100 MHz, rounded up) before the first sclk rise, and rises at least 2 cycles (20 ns) after the last sclk rise; sclk is low whenever cs_n is high.
- R5: Every sclk high phase and every sclk low phase inside a frame lasts at least 2 system cycles (20 ns), giving a period of at least 40 ns.
- R6: In pulse mode (pulse_load = 1 at acceptance) ldac_n falls once per frame, at least 3 cycles (30 ns) after cs_n rises, and stays low at least 3 cycles.
- R7: In tied mode (pulse_load = 0 at acceptance) ldac_n is driven low from acceptance onward and produces no pulse after the frame.
- R8: cs_n stays high for at least 3 cycles (30 ns) between two frames.
- R9: req_ready is 1 only while idle; a request is taken on a clock edge with req_valid and req_ready both 1, and req_valid, req_code and pulse_load presented while req_ready is 0 have no effect.
- R10: done is a single-cycle pulse asserted in the cycle ldac_n returns high (pulse mode) or at least 3 cycles after cs_n rises (tied mode); shadow_code equals the code of that transaction from the done cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_code | input | 14 | Code to write |
| pulse_load | input | 1 | 1: timed load pulse after frame; 0: load line held low |
| req_ready | output | 1 | Controller idle, request may be taken |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data to the DAC |
| ldac_n | output | 1 | Active-low load strobe |
| done | output | 1 | One-cycle end-of-transaction pulse |
| shadow_code | output | 14 | Last code written |

## Verification
Directed codes all-zeros, all-ones and the two alternating patterns separate a stuck data line, a bit-order reversal and an off-by-one shift. A fixed-seed random series mixes codes with both load modes, so a change of mode between frames is exercised in both directions and the strobe gating is told apart from the frame timing. A request held on the inputs with a different code and mode while the controller is busy shows whether the handshake lets anything through. Each timing minimum is measured in cycles on every frame, so a shortened delay shows up whatever the data.

// File: rtl/dacwr_pkg.sv
package dacwr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_PRELD,
        ST_LOAD,
        ST_GAP
    } dacwr_st_e;

    // nanoseconds to whole clock cycles, rounded up
    function automatic int ns2cyc(input int ns, input int mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dacwr_timer.sv
module dacwr_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/dacwr_shifter.sv
module dacwr_shifter #(
    parameter int N = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] din,
    input  logic         shift,
    output logic         msb
);
    logic [N-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load)
            sh_d = din;
        else if (shift)
            sh_d = {sh_q[N-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign msb = sh_q[N-1];
endmodule

// File: rtl/dacwr_ctrl.sv
module dacwr_ctrl
    import dacwr_pkg::*;
#(
    parameter int CLK_MHZ       = 100,
    parameter int CODE_W        = 14,
    parameter int SCLK_HALF_CYC = 2,
    parameter int T_CSSU_NS     = 15,
    parameter int T_PHASE_NS    = 20,
    parameter int T_CSHOLD_NS   = 20,
    parameter int T_CSGAP_NS    = 30,
    parameter int T_LDSU_NS     = 30,
    parameter int T_LDW_NS      = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CODE_W-1:0] req_code,
    input  logic              pulse_load,
    output logic              req_ready,
    output logic              cs_n,
    output logic              sclk,
    output logic              sdo,
    output logic              ldac_n,
    output logic              done,
    output logic [CODE_W-1:0] shadow_code
);
    localparam int HALF_C = imax(imax(SCLK_HALF_CYC, ns2cyc(T_PHASE_NS, CLK_MHZ)), 1);
    localparam int SU_C   = imax(ns2cyc(T_CSSU_NS, CLK_MHZ), HALF_C);
    localparam int TAIL_C = imax(ns2cyc(T_CSHOLD_NS, CLK_MHZ), 1);
    localparam int GAP_C  = imax(ns2cyc(T_CSGAP_NS, CLK_MHZ), 1);
    localparam int PRE_C  = imax(ns2cyc(T_LDSU_NS, CLK_MHZ), 1);
    // strobe width also tops up the select-high gap when the delay alone is short
    localparam int LDW_C  = imax(imax(ns2cyc(T_LDW_NS, CLK_MHZ), GAP_C - PRE_C), 1);
    localparam int MAXC   = imax(imax(imax(HALF_C, SU_C), imax(TAIL_C, GAP_C)), imax(PRE_C, LDW_C));
    localparam int TW     = $clog2(MAXC + 1);
    localparam int BW     = $clog2(CODE_W + 1);

    typedef struct packed {
        dacwr_st_e         st;
        logic              cs_n;
        logic              sclk;
        logic              ldac_n;
        logic              done;
        logic              pulse;
        logic [BW-1:0]     bits;
        logic [CODE_W-1:0] code;
        logic [CODE_W-1:0] shadow;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic          tmr_ld, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          sh_ld, sh_sh;

    dacwr_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_ld),
        .val   (tmr_val),
        .zero  (tmr_zero)
    );

    dacwr_shifter #(.N(CODE_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_ld),
        .din   (req_code),
        .shift (sh_sh),
        .msb   (sdo)
    );

    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        tmr_ld  = 1'b0;
        tmr_val = '0;
        sh_ld   = 1'b0;
        sh_sh   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    sh_ld      = 1'b1;
                    r_d.cs_n   = 1'b0;
                    r_d.pulse  = pulse_load;
                    r_d.ldac_n = pulse_load;
                    r_d.code   = req_code;
                    r_d.bits   = BW'(CODE_W - 1);
                    tmr_ld     = 1'b1;
                    tmr_val    = TW'(SU_C - 1);
                    r_d.st     = ST_SETUP;
                end
            end
            ST_SETUP, ST_LOW: begin
                if (tmr_zero) begin
                    r_d.sclk = 1'b1;
                    tmr_ld   = 1'b1;
                    tmr_val  = TW'(HALF_C - 1);
                    r_d.st   = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tmr_zero) begin
                    r_d.sclk = 1'b0;
                    tmr_ld   = 1'b1;
                    if (r_q.bits != '0) begin
                        r_d.bits = r_q.bits - 1'b1;
                        sh_sh    = 1'b1;
                        tmr_val  = TW'(HALF_C - 1);
                        r_d.st   = ST_LOW;
                    end else begin
                        tmr_val  = TW'(TAIL_C - 1);
                        r_d.st   = ST_TAIL;
                    end
                end
            end
            ST_TAIL: begin
                if (tmr_zero) begin
                    r_d.cs_n = 1'b1;
                    tmr_ld   = 1'b1;
                    if (r_q.pulse) begin
                        tmr_val = TW'(PRE_C - 1);
                        r_d.st  = ST_PRELD;
                    end else begin
                        tmr_val = TW'(GAP_C - 1);
                        r_d.st  = ST_GAP;
                    end
                end
            end
            ST_PRELD: begin
                if (tmr_zero) begin
                    r_d.ldac_n = 1'b0;
                    tmr_ld     = 1'b1;
                    tmr_val    = TW'(LDW_C - 1);
                    r_d.st     = ST_LOAD;
                end
            end
            ST_LOAD, ST_GAP: begin
                if (tmr_zero) begin
                    if (r_q.st == ST_LOAD) r_d.ldac_n = 1'b1;
                    r_d.done   = 1'b1;
                    r_d.shadow = r_q.code;
                    r_d.st     = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.cs_n   <= 1'b1;
            r_q.sclk   <= 1'b0;
            r_q.ldac_n <= 1'b1;
            r_q.done   <= 1'b0;
            r_q.pulse  <= 1'b1;
            r_q.bits   <= '0;
            r_q.code   <= '0;
            r_q.shadow <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready   = (r_q.st == ST_IDLE);
    assign cs_n        = r_q.cs_n;
    assign sclk        = r_q.sclk;
    assign ldac_n      = r_q.ldac_n;
    assign done        = r_q.done;
    assign shadow_code = r_q.shadow;
endmodule

// File: rtl/dacwr_ctrl_chk.sv
module dacwr_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic cs_n,
    input logic sclk,
    input logic sdo,
    input logic ldac_n,
    input logic done
);
    // R4: serial clock parked low outside a frame
    p_sclk_parked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R3: data held through each high phase
    p_sdo_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdo));

    // R6: strobe falls only after select has been high for three samples
    p_ld_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ldac_n) && cs_n) |-> ($past(cs_n) && $past(cs_n, 2)));

    // R9: idle means no frame, and taking a request makes the block busy
    p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cs_n && !sclk));

    p_take_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !cs_n));

    // R10: done is single-cycle and lands in idle
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);
endmodule

bind dacwr_ctrl dacwr_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .sdo       (sdo),
    .ldac_n    (ldac_n),
    .done      (done)
);

// File: tb/dacwr_ctrl_tb_top.sv
module dacwr_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [13:0] req_code = '0;
    logic        pulse_load = 1'b1;
    logic        req_ready, cs_n, sclk, sdo, ldac_n, done;
    logic [13:0] shadow_code;

    always #5 clk = ~clk;

    dacwr_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_code    (req_code),
        .pulse_load  (pulse_load),
        .req_ready   (req_ready),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .sdo         (sdo),
        .ldac_n      (ldac_n),
        .done        (done),
        .shadow_code (shadow_code)
    );

    // minimums in 10 ns cycles, rounded up
    localparam int MIN_SU = 2, MIN_PH = 2, MIN_HOLD = 2, MIN_GAP = 3, MIN_LDSU = 3, MIN_LDW = 3;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit ld_ok(input int fall, input int rise, input int min_w);
        return (rise - fall) >= min_w;
    endfunction

    // expected transaction
    logic [13:0] exp_code = '0;
    logic        exp_pulse = 1'b1;

    // monitor state
    int cyc = 0;
    logic p_cs = 1, p_sclk = 0, p_sdo = 0, p_ldac = 1, p_done = 0;
    int t_cs_fall = -1000, t_cs_rise = -1000, t_edge = -1000, t_last_rise = -1000;
    int t_ld_fall = -1000, t_ld_rise = -1000;
    int bitcnt = 0, pulses = 0;
    logic [13:0] cap = '0;
    bit sdo_bad = 0, rdy_bad = 0, in_pulse = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (sclk && p_sclk && (sdo != p_sdo)) sdo_bad = 1;
            if (!cs_n && req_ready) rdy_bad = 1;
            if (cs_n && sclk) chk(0, "R4 sclk high outside frame", 1, 0);
            if (done && p_done) chk(0, "R10 done longer than one cycle", 2, 1);
            if (!cs_n && p_cs) begin
                chk(cyc - t_cs_rise >= MIN_GAP, "R8 cs high gap", cyc - t_cs_rise, MIN_GAP);
                bitcnt = 0; pulses = 0; sdo_bad = 0; rdy_bad = 0; cap = '0;
            end
            if (sclk && !p_sclk) begin
                if (bitcnt == 0)
                    chk(cyc - t_cs_fall >= MIN_SU, "R4 cs fall to first rise", cyc - t_cs_fall, MIN_SU);
                else
                    chk(cyc - t_edge >= MIN_PH, "R5 low phase", cyc - t_edge, MIN_PH);
                cap = {cap[12:0], sdo};
                bitcnt++;
                t_edge = cyc; t_last_rise = cyc;
            end
            if (!sclk && p_sclk) begin
                chk(cyc - t_edge >= MIN_PH, "R5 high phase", cyc - t_edge, MIN_PH);
                t_edge = cyc;
            end
            if (!cs_n && p_cs) t_cs_fall = cyc;
            if (cs_n && !p_cs) begin
                t_cs_rise = cyc;
                chk(bitcnt == 14, "R2 bit count", bitcnt, 14);
                chk(cap == exp_code, "R2 captured code", cap, exp_code);
                chk(cyc - t_last_rise >= MIN_HOLD, "R4 last rise to cs rise", cyc - t_last_rise, MIN_HOLD);
                chk(!sdo_bad, "R3 sdo moved while sclk high", sdo_bad, 0);
                chk(!rdy_bad, "R9 ready during frame", rdy_bad, 0);
            end
            if (!ldac_n && p_ldac && cs_n) begin
                in_pulse = 1; t_ld_fall = cyc;
                chk(exp_pulse, "R7 pulse in tied mode", 1, 0);
                chk(cyc - t_cs_rise >= MIN_LDSU, "R6 cs rise to load fall", cyc - t_cs_rise, MIN_LDSU);
            end
            if (ldac_n && !p_ldac && in_pulse) begin
                in_pulse = 0; pulses++; t_ld_rise = cyc;
                chk(ld_ok(t_ld_fall, cyc, MIN_LDW), "R6 load width", cyc - t_ld_fall, MIN_LDW);
            end
            if (done) begin
                if (exp_pulse) begin
                    chk(pulses == 1, "R6 one pulse per frame", pulses, 1);
                    chk(t_ld_rise == cyc, "R10 done with load rise", t_ld_rise, cyc);
                end else begin
                    chk(pulses == 0, "R7 no pulse", pulses, 0);
                    chk(ldac_n == 1'b0, "R7 load held low", ldac_n, 0);
                    chk(cyc - t_cs_rise >= MIN_GAP, "R10 done after gap", cyc - t_cs_rise, MIN_GAP);
                end
            end
            p_cs = cs_n; p_sclk = sclk; p_sdo = sdo; p_ldac = ldac_n; p_done = done;
        end
    end

    task automatic send(input logic [13:0] c, input logic p, input bit noise);
        while (!req_ready) @(negedge clk);
        exp_code = c; exp_pulse = p;
        req_valid = 1'b1; req_code = c; pulse_load = p;
        @(negedge clk);
        if (noise) begin
            req_code = ~c; pulse_load = ~p;
            for (int i = 0; i < 10; i++) begin
                chk(!req_ready, "R9 busy holds ready low", req_ready, 0);
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        chk(shadow_code == c, "R10 shadow code", shadow_code, c);
        @(negedge clk);
        if (noise) begin
            chk(cs_n && req_ready, "R9 no frame from ignored request", cs_n, 1);
            chk(shadow_code == c, "R9 shadow unchanged by ignored request", shadow_code, c);
        end
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h1A2B);
        #23;
        chk(cs_n == 1 && sclk == 0 && sdo == 0, "R1 reset serial lines", {cs_n, sclk, sdo}, 3'b100);
        chk(ldac_n == 1 && done == 0 && req_ready == 1, "R1 reset control", {ldac_n, done, req_ready}, 3'b101);
        chk(shadow_code == 0, "R1 reset shadow", shadow_code, 0);
        rst_n = 1'b1;
        @(negedge clk);
        send(14'h0000, 1'b1, 0);
        send(14'h3FFF, 1'b1, 0);
        send(14'h2AAA, 1'b0, 0);
        send(14'h1555, 1'b1, 0);
        send(14'h2001, 1'b0, 0);
        send(14'h0C3A, 1'b1, 1);
        send(14'h1F0F, 1'b0, 1);
        for (int k = 0; k < 40; k++)
            send(14'($urandom), 1'($urandom), ($urandom % 5) == 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule